// File: doc/BRIEF.md
# Indirect SRAM Access Port

This block gives a host on a simple register bus access to a local single-port SRAM through two 16-bit registers. One holds an SRAM byte address (the pointer). The other is a data window. A read or write of the window goes to the SRAM location named by the pointer. The pointer then advances by itself, so a host can stream through a buffer without rewriting the address between transfers. The pointer advances by one after a byte transfer and by two after a word transfer. A byte transfer on the odd (high) byte lane is refused and flagged.

The pointer and window exist only while `slave_mode` is high. When `slave_mode` is low, the same two register indexes hold the read-command and write-command active-time values that a bus-master engine uses. Window traffic then never reaches the SRAM, and the pointer does not move.

Top module: `sram_window_port`

## Requirements
- R1: After reset, the pointer is zero, `host_rvalid` and `host_err` are low, `cmd_rd_time` equals RD_DEF and `cmd_wr_time` equals WR_DEF.
- R2: In slave mode, a write to index 1 loads the pointer from `host_wdata[AW-1:0]` and ignores the upper bits. A read of index 1 returns the pointer, zero-extended, on `host_rdata` with `host_rvalid` high in the next cycle.
- R3: In slave mode, a write to index 0 stores data at the pointer. A word write (`host_word`=1) puts `host_wdata[7:0]` at the pointer and `host_wdata[15:8]` at pointer+1. A low-lane byte write stores `host_wdata[7:0]` only.
- R4: In slave mode, a read of index 0 returns, in the next cycle with `host_rvalid` high, the data at the pointer value before the advance. A word read gives {byte at pointer+1, byte at pointer}. A byte read gives {8'h00, byte at pointer}.
- R5: Every accepted window access, read or write, advances the pointer by 2 for a word and by 1 for a low-lane byte. The new value is visible from the cycle after the access.
- R6: A byte access (`host_word`=0) with `host_lane_hi`=1 to index 0 is refused. No SRAM cycle is issued, the pointer and the SRAM are left unchanged, no read data is returned, and `host_err` is high for exactly the next cycle.
- R7: The pointer and the byte after it wrap modulo 2^AW at the end of the SRAM address range.
- R8: With `slave_mode`=0, index 0 is the read active time and index 1 is the write active time. A write loads `host_wdata[TW-1:0]` into the register, which drives `cmd_rd_time` or `cmd_wr_time` from the next cycle. A read returns the value, zero-extended, in the next cycle. The SRAM is never enabled and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: pointer/window mode, 0: master timing mode |
| host_req | input | 1 | Single-cycle register access strobe |
| host_wr | input | 1 | 1 write, 0 read |
| host_idx | input | 1 | Register index: 0 window / read time, 1 pointer / write time |
| host_word | input | 1 | 1 word access, 0 byte access |
| host_lane_hi | input | 1 | For byte access: 1 odd (high) lane, 0 even lane |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data returned this cycle |
| host_err | output | 1 | One-cycle pulse after a refused access |
| sram_en | output | 1 | SRAM cycle enable |
| sram_we | output | 1 | SRAM write enable |
| sram_word | output | 1 | SRAM access is two bytes |
| sram_addr | output | AW | SRAM byte address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after sram_en |
| cmd_rd_time | output | TW | Read command active time |
| cmd_wr_time | output | TW | Write command active time |

## Verification
The bench builds the block with AW=6. That gives a 64-byte SRAM, so word and byte streams cross the wrap point within a few dozen accesses, including a word that starts at the last byte. TW=4 is kept. The bench uses RD_DEF=5 and WR_DEF=7, so that a swap of the two master timing registers shows up at reset. Random traffic mixes both modes, both widths and both lanes, so that refused accesses and mode changes fall between ordinary transfers.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;

   // what the cycle after an access returns on the host read bus
   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_WORD,
      RSEL_BYTE,
      RSEL_PTR,
      RSEL_TIM0,
      RSEL_TIM1
   } rsel_e;

   typedef struct packed {
      logic       sram_go;
      logic       sram_we;
      logic       sram_word;
      logic       ptr_load;
      logic       refuse;
      logic [1:0] tim_load;
      rsel_e      rsel;
   } host_cmd_t;

endpackage

// File: rtl/sram_window_decode.sv
module sram_window_decode
   import sram_window_pkg::*;
(
   input  logic      req,
   input  logic      wr,
   input  logic      idx,
   input  logic      word,
   input  logic      lane_hi,
   input  logic      slave_mode,
   output host_cmd_t cmd
);

   always_comb begin
      cmd      = '0;
      cmd.rsel = RSEL_NONE;
      if (req) begin
         if (slave_mode) begin
            if (idx) begin
               if (wr) cmd.ptr_load = 1'b1;
               else    cmd.rsel     = RSEL_PTR;
            end else if (!word && lane_hi) begin
               cmd.refuse = 1'b1;
            end else begin
               cmd.sram_go   = 1'b1;
               cmd.sram_we   = wr;
               cmd.sram_word = word;
               if (!wr) cmd.rsel = word ? RSEL_WORD : RSEL_BYTE;
            end
         end else begin
            if (wr) cmd.tim_load[idx] = 1'b1;
            else    cmd.rsel = idx ? RSEL_TIM1 : RSEL_TIM0;
         end
      end
   end

endmodule

// File: rtl/sram_window_ptr.sv
module sram_window_ptr #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          step_word,
   output logic [AW-1:0] ptr
);

   localparam logic [AW-1:0] STEP_B = AW'(1);
   localparam logic [AW-1:0] STEP_W = AW'(2);

   // natural AW-bit arithmetic gives the wrap at the end of the range
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (step) ptr <= ptr + (step_word ? STEP_W : STEP_B);
   end

endmodule

// File: rtl/sram_window_timing.sv
module sram_window_timing #(
   parameter int              TW   = 4,
   parameter int              N    = 2,
   parameter logic [N*TW-1:0] DEFS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  load,
   input  logic [TW-1:0] wval,
   output logic [TW-1:0] regs [N]
);

   for (genvar g = 0; g < N; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       regs[g] <= DEFS[g*TW +: TW];
         else if (load[g]) regs[g] <= wval;
      end
   end

endmodule

// File: rtl/sram_window_port.sv
module sram_window_port
   import sram_window_pkg::*;
#(
   parameter int AW     = 10,
   parameter int TW     = 4,
   parameter int RD_DEF = 5,
   parameter int WR_DEF = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slave_mode,
   input  logic          host_req,
   input  logic          host_wr,
   input  logic          host_idx,
   input  logic          host_word,
   input  logic          host_lane_hi,
   input  logic [15:0]   host_wdata,
   output logic [15:0]   host_rdata,
   output logic          host_rvalid,
   output logic          host_err,
   output logic          sram_en,
   output logic          sram_we,
   output logic          sram_word,
   output logic [AW-1:0] sram_addr,
   output logic [15:0]   sram_wdata,
   input  logic [15:0]   sram_rdata,
   output logic [TW-1:0] cmd_rd_time,
   output logic [TW-1:0] cmd_wr_time
);

   localparam int NTIM = 2;
   localparam logic [NTIM*TW-1:0] TIM_DEFS = {TW'(WR_DEF), TW'(RD_DEF)};

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("sram_window_port: AW must lie in 2..16");
   end
   if (TW < 1 || TW > 16) begin : g_bad_tw
      $error("sram_window_port: TW must lie in 1..16");
   end
   if (RD_DEF < 1 || RD_DEF >= (1 << TW) || WR_DEF < 1 || WR_DEF >= (1 << TW)) begin : g_bad_def
      $error("sram_window_port: timing defaults must be nonzero and fit TW bits");
   end

   host_cmd_t     cmd;
   logic [AW-1:0] ptr_q;
   logic [TW-1:0] tim [NTIM];
   rsel_e         rsel_q;
   logic          err_q;

   sram_window_decode u_dec (
      .req        (host_req),
      .wr         (host_wr),
      .idx        (host_idx),
      .word       (host_word),
      .lane_hi    (host_lane_hi),
      .slave_mode (slave_mode),
      .cmd        (cmd)
   );

   sram_window_ptr #(.AW(AW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd.ptr_load),
      .load_val  (host_wdata[AW-1:0]),
      .step      (cmd.sram_go),
      .step_word (cmd.sram_word),
      .ptr       (ptr_q)
   );

   sram_window_timing #(.TW(TW), .N(NTIM), .DEFS(TIM_DEFS)) u_tim (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cmd.tim_load),
      .wval  (host_wdata[TW-1:0]),
      .regs  (tim)
   );

   assign sram_en     = cmd.sram_go;
   assign sram_we     = cmd.sram_we;
   assign sram_word   = cmd.sram_word;
   assign sram_addr   = ptr_q;
   assign sram_wdata  = host_wdata;
   assign cmd_rd_time = tim[0];
   assign cmd_wr_time = tim[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_q <= RSEL_NONE;
         err_q  <= 1'b0;
      end else begin
         rsel_q <= cmd.rsel;
         err_q  <= cmd.refuse;
      end
   end

   always_comb begin
      case (rsel_q)
         RSEL_WORD: host_rdata = sram_rdata;
         RSEL_BYTE: host_rdata = {8'h00, sram_rdata[7:0]};
         RSEL_PTR:  host_rdata = 16'(ptr_q);
         RSEL_TIM0: host_rdata = 16'(tim[0]);
         RSEL_TIM1: host_rdata = 16'(tim[1]);
         default:   host_rdata = '0;
      endcase
   end

   assign host_rvalid = (rsel_q != RSEL_NONE);
   assign host_err    = err_q;

endmodule

// File: rtl/sram_window_port_chk.sv
module sram_window_port_chk #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          slave_mode,
   input logic          host_req,
   input logic          host_idx,
   input logic          host_word,
   input logic          host_lane_hi,
   input logic          host_err,
   input logic          host_rvalid,
   input logic          sram_en,
   input logic          sram_we,
   input logic          sram_word,
   input logic [AW-1:0] ptr
);

   logic odd_refuse;
   assign odd_refuse = host_req && slave_mode && !host_idx && !host_word && host_lane_hi;

   // R6
   odd_lane_nosram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      odd_refuse |-> !sram_en);

   // R6
   odd_lane_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      odd_refuse |=> host_err && ptr == $past(ptr));

   // R5
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_en && sram_word |=> ptr == AW'($past(ptr) + AW'(2)));

   // R5
   byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_en && !sram_word |=> ptr == AW'($past(ptr) + AW'(1)));

   // R8
   master_nosram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_mode |-> !sram_en);

   // R4
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_en && !sram_we |=> host_rvalid);

   // R6
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> $past(host_req));

endmodule

bind sram_window_port sram_window_port_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slave_mode   (slave_mode),
   .host_req     (host_req),
   .host_idx     (host_idx),
   .host_word    (host_word),
   .host_lane_hi (host_lane_hi),
   .host_err     (host_err),
   .host_rvalid  (host_rvalid),
   .sram_en      (sram_en),
   .sram_we      (sram_we),
   .sram_word    (sram_word),
   .ptr          (ptr_q)
);

// File: tb/sram_window_port_tb.sv
module sram_window_port_tb;

   localparam int AW = 6;
   localparam int TW = 4;
   localparam int RD_DEF = 5;
   localparam int WR_DEF = 7;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slave_mode = 1'b1;
   logic          host_req = 1'b0, host_wr = 1'b0, host_idx = 1'b0;
   logic          host_word = 1'b0, host_lane_hi = 1'b0;
   logic [15:0]   host_wdata = '0;
   logic [15:0]   host_rdata;
   logic          host_rvalid, host_err;
   logic          sram_en, sram_we, sram_word;
   logic [AW-1:0] sram_addr;
   logic [15:0]   sram_wdata;
   logic [15:0]   sram_rdata = '0;
   logic [TW-1:0] cmd_rd_time, cmd_wr_time;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0]    mem     [DEPTH];
   logic [7:0]    exp_mem [DEPTH];
   logic [AW-1:0] exp_ptr = '0;
   logic [TW-1:0] exp_trd = TW'(RD_DEF);
   logic [TW-1:0] exp_twr = TW'(WR_DEF);

   always #2 clk = ~clk;

   sram_window_port #(.AW(AW), .TW(TW), .RD_DEF(RD_DEF), .WR_DEF(WR_DEF)) u_dut (
      .clk, .rst_n, .slave_mode, .host_req, .host_wr, .host_idx, .host_word,
      .host_lane_hi, .host_wdata, .host_rdata, .host_rvalid, .host_err,
      .sram_en, .sram_we, .sram_word, .sram_addr, .sram_wdata, .sram_rdata,
      .cmd_rd_time, .cmd_wr_time
   );

   // SRAM model: byte addressed, one-cycle read latency
   logic [AW-1:0] addr_nx;
   assign addr_nx = sram_addr + AW'(1);

   always @(posedge clk) begin
      if (sram_en) begin
         if (sram_we) begin
            mem[sram_addr] <= sram_wdata[7:0];
            if (sram_word) mem[addr_nx] <= sram_wdata[15:8];
         end else begin
            sram_rdata <= {mem[addr_nx], mem[sram_addr]};
         end
      end
   end

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one host access, expected results computed from the requirements
   task automatic op(string tag, bit wr, bit idx, bit word, bit lane, logic [15:0] wd);
      logic [15:0]   er = '0;
      bit            ev = 1'b0;
      bit            ee = 1'b0;
      logic [AW-1:0] p  = exp_ptr;
      logic [AW-1:0] p1 = exp_ptr + AW'(1);
      if (slave_mode) begin
         if (idx) begin
            if (wr) exp_ptr = wd[AW-1:0];
            else begin ev = 1'b1; er = 16'(exp_ptr); end
         end else if (!word && lane) begin
            ee = 1'b1;
         end else begin
            if (wr) begin
               exp_mem[p] = wd[7:0];
               if (word) exp_mem[p1] = wd[15:8];
            end else begin
               ev = 1'b1;
               er = word ? {exp_mem[p1], exp_mem[p]} : {8'h00, exp_mem[p]};
            end
            exp_ptr = exp_ptr + (word ? AW'(2) : AW'(1));
         end
      end else begin
         if (wr) begin
            if (idx) exp_twr = wd[TW-1:0];
            else     exp_trd = wd[TW-1:0];
         end else begin
            ev = 1'b1;
            er = idx ? 16'(exp_twr) : 16'(exp_trd);
         end
      end
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_idx = idx; host_word = word;
      host_lane_hi = lane; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0;
      chk({tag, " rvalid"}, 16'(host_rvalid), 16'(ev));
      chk({tag, " err"}, 16'(host_err), 16'(ee));
      if (ev) chk({tag, " rdata"}, host_rdata, er);
      chk({tag, " rd_time"}, 16'(cmd_rd_time), 16'(exp_trd));
      chk({tag, " wr_time"}, 16'(cmd_wr_time), 16'(exp_twr));
   endtask

   task automatic set_ptr(logic [15:0] v);
      op("R2", 1'b1, 1'b1, 1'b1, 1'b0, v);
   endtask

   task automatic read_ptr(string tag);
      op(tag, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = 8'($urandom);
         exp_mem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rvalid", 16'(host_rvalid), 16'h0);
      chk("R1 err", 16'(host_err), 16'h0);
      chk("R1 rd_time", 16'(cmd_rd_time), 16'(RD_DEF));
      chk("R1 wr_time", 16'(cmd_wr_time), 16'(WR_DEF));
      rst_n = 1'b1;
      read_ptr("R1 ptr");

      // R2 pointer load and readback, upper bits dropped
      set_ptr(16'h002A); read_ptr("R2");
      set_ptr(16'hFFC5); read_ptr("R2 upper");

      // R3 / R4 writes and pre-increment reads
      set_ptr(16'd4);  op("R3", 1'b1, 1'b0, 1'b1, 1'b0, 16'hBEEF);
      set_ptr(16'd4);  op("R4", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
      set_ptr(16'd10); op("R3", 1'b1, 1'b0, 1'b0, 1'b0, 16'h5A3C);
      set_ptr(16'd10); op("R4", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

      // R5 step sizes
      set_ptr(16'd8); op("R5", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0); read_ptr("R5 byte");
      op("R5", 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234); read_ptr("R5 word");

      // R6 odd-lane refusal: pointer and memory untouched
      set_ptr(16'd20);
      op("R6", 1'b1, 1'b0, 1'b0, 1'b1, 16'h0077);
      op("R6", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
      read_ptr("R6 ptr");
      op("R6 mem", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

      // R7 wrap
      set_ptr(16'd63); op("R7", 1'b1, 1'b0, 1'b0, 1'b0, 16'h00A1); read_ptr("R7 byte");
      set_ptr(16'd62); op("R7", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0); read_ptr("R7 word");
      set_ptr(16'd63); op("R7", 1'b1, 1'b0, 1'b1, 1'b0, 16'hC3D2); read_ptr("R7 split");
      set_ptr(16'd63); op("R7 split rd", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

      // R8 master mode timing registers
      set_ptr(16'd30);
      slave_mode = 1'b0;
      op("R8", 1'b1, 1'b0, 1'b1, 1'b0, 16'h00A9);
      op("R8", 1'b1, 1'b1, 1'b1, 1'b0, 16'hFF03);
      op("R8", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
      op("R8", 1'b0, 1'b1, 1'b0, 1'b1, 16'h0);
      @(negedge clk);
      slave_mode = 1'b1;
      read_ptr("R8 ptr");
      op("R8 mem", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

      // random traffic across all requirements
      for (int n = 0; n < 600; n++) begin
         int sel = int'($urandom_range(0, 99));
         @(negedge clk);
         slave_mode = (sel >= 8);
         op(slave_mode ? "R5 rnd" : "R8 rnd", 1'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom), 1'($urandom_range(0, 3) == 0), 16'($urandom));
      end
      slave_mode = 1'b1;
      for (int a = 0; a < DEPTH; a++) begin
         set_ptr(16'(a));
         op("R4 sweep", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule